// File: doc/BRIEF.md
# External interrupt pin conditioner

The block turns six asynchronous interrupt pins into six request flags. Each pin is synchronized to the block clock. The pin is then watched for the edge selected by its polarity bit. A detected edge sets a sticky pending flag, and the flag stays set until software clears it.

Pin 0 is the only one that can instead work as a high-level request. In that mode its flag follows the synchronized pin.

Software configures the block through a simple register bus. A mode register holds the polarity bits and the level enable for pin 0. A clear register takes an identifier code and drops the flag of the one pin that the code names.

Top module: `extint_cond`

## Requirements
- R1: While reset is asserted and right after it, all six flags are 0 and the mode register is 0. Every pin is then rising-edge triggered and pin 0 is in edge mode.
- R2: With its polarity bit at 0, a low-to-high transition on pin k sets flag k. The flag reads 1 at most three clock edges after the pin changes.
- R3: The polarity bit of pin k is bit k+2 of the mode register, at address 0xF6. At 1, a high-to-low transition sets flag k.
- R4: A transition opposite to the selected polarity leaves the flag unchanged. So does a write to the mode register that changes only polarity bits.
- R5: An edge-mode flag stays set until a write to the clear register, at address 0xF8, carries code 0x0A+k. Code 0x0A through 0x0F clear flags 0 through 5, one flag per write.
- R6: A clear-register write whose value is outside 0x0A..0x0F leaves all flags unchanged.
- R7: If an edge is detected in the same cycle as a clear write for that flag, the flag ends up set.
- R8: Bit 1 of the mode register is the level enable for pin 0. At 1, flag 0 follows the synchronized pin and bit 2 has no effect. A clear write has no lasting effect while the pin is high.
- R9: A read at address 0xF6 returns bit 1 as stored, with bit 0 and bits 7..2 at 0. A read at any other address returns 0.
- R10: When pin 0 is switched from level mode back to edge mode while its flag is 1, the flag stays 1 until code 0x0A is written.
- R11: Pins 1 to 5 have no level mode. With bit 1 set, their flags stay sticky.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the address on `addr` |
| pins | input | 6 | Asynchronous interrupt pins |
| irq | output | 6 | Pending request flags, one per pin |

## Verification
A detected edge and a clear write for the same flag can fall into one cycle. The bench provokes this on a flag that is already set. It first returns the pin to idle. It then times a new active edge so that the detection cycle lines up with the clock edge that takes the clear write. The flag must read 1 after that edge, and a later clear on its own must still drop it. A second overlap is a clear that lands while pin 0 is held high in level mode. The flag must stay 1 there, because the pin keeps restoring it.

// File: rtl/extint_cond.sv
module extint_cond #(
  parameter int N         = 6,
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int MODE_ADDR = 'hF6,
  parameter int CLR_ADDR  = 'hF8,
  parameter int CLR_BASE  = 'h0A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  pins,
  output logic [N-1:0]  irq
);
  localparam int POL_LSB = 2;

  logic [N-1:0] s1, s2, prev, pol, clr, hit, nxt;
  logic         lvl;

  wire mode_wr = wr_en && (addr == AW'(MODE_ADDR));
  wire clr_wr  = wr_en && (addr == AW'(CLR_ADDR));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pol <= '0;
      lvl <= 1'b0;
    end else if (mode_wr) begin
      pol <= wdata[POL_LSB +: N];
      lvl <= wdata[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
    end else begin
      s1   <= pins;
      s2   <= s1;
      prev <= s2;
    end

  assign hit = (s2 ^ prev) & (s2 ^ pol);

  for (genvar k = 0; k < N; k++) begin : g_flag
    assign clr[k] = clr_wr && (wdata == DW'(CLR_BASE + k));
    if (k == 0) begin : g_lvl
      assign nxt[k] = lvl ? s2[k] : (hit[k] | (irq[k] & ~clr[k]));
    end else begin : g_edge
      assign nxt[k] = hit[k] | (irq[k] & ~clr[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= '0;
    else        irq <= nxt;

  assign rdata = (addr == AW'(MODE_ADDR)) ? (DW'(lvl) << 1) : '0;
endmodule

// File: rtl/extint_cond_chk.sv
module extint_cond_chk #(
  parameter int N        = 6,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int CLR_ADDR = 'hF8,
  parameter int CLR_BASE = 'h0A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [N-1:0]  irq,
  input logic [N-1:0]  s2,
  input logic [N-1:0]  prev,
  input logic [N-1:0]  pol,
  input logic          lvl
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> irq == '0);

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl) |-> irq[0] == $past(s2[0]));

  for (genvar k = 1; k < N; k++) begin : g_chk
    // R5
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq[k]) && !irq[k]) |->
        $past(wr_en && addr == AW'(CLR_ADDR) && wdata == DW'(CLR_BASE + k)));
    // R7
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s2[k] != prev[k] && s2[k] != pol[k]) |-> irq[k]);
  end

  // R9
  always @(negedge clk)
    if (rst_n) rdata_rsvd_chk: assert (rdata[0] == 1'b0 && rdata[DW-1:2] == '0);
endmodule

bind extint_cond extint_cond_chk #(.N(N), .AW(AW), .DW(DW), .CLR_ADDR(CLR_ADDR), .CLR_BASE(CLR_BASE))
  u_chk (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
         .irq(irq), .s2(s2), .prev(prev), .pol(pol), .lvl(lvl));

// File: tb/extint_cond_bench.sv
module extint_cond_bench;
  logic       clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [5:0] pins = 0, irq;
  int tests = 0, fails = 0;
  bit done = 0;

  extint_cond u_extint_cond (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                             .rdata(rdata), .pins(pins), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic drive(logic [5:0] v);
    @(negedge clk); pins = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [5:0] edges(logic [5:0] o, logic [5:0] n, logic [5:0] p);
    return (o ^ n) & (n ^ p);
  endfunction

  function automatic logic [5:0] after_clr(logic [5:0] f, logic [7:0] code);
    if (code >= 8'h0A && code <= 8'h0F) f[code - 8'h0A] = 1'b0;
    return f;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp, pol, np;
    logic [7:0] code;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", {2'b0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    addr = 8'hF6; #1;
    chk("R1 mode after reset", rdata, 8'h00);
    addr = 0;

    drive(6'h3F);
    chk("R2 rising sets all", {2'b0, irq}, 8'h3F);
    drive(6'h00);
    chk("R4 falling ignored", {2'b0, irq}, 8'h3F);
    wr(8'hF8, 8'h10);
    chk("R6 bad code", {2'b0, irq}, 8'h3F);
    wr(8'hF8, 8'h0C);
    chk("R5 clear pin2", {2'b0, irq}, 8'h3B);
    for (int k = 0; k < 6; k++) wr(8'hF8, 8'h0A + 8'(k));
    chk("R5 clear all", {2'b0, irq}, 8'h00);

    wr(8'hF6, 8'hFD);
    chk("R4 polarity write no edge", {2'b0, irq}, 8'h00);
    addr = 8'hF6; #1;
    chk("R9 readback", rdata, 8'h00);
    addr = 8'h00; #1;
    chk("R9 other addr", rdata, 8'h00);
    drive(6'h3F);
    chk("R4 rising ignored falling mode", {2'b0, irq}, 8'h00);
    drive(6'h00);
    chk("R3 falling sets", {2'b0, irq}, 8'h3F);
    for (int k = 0; k < 6; k++) wr(8'hF8, 8'h0A + 8'(k));
    wr(8'hF6, 8'h00);

    drive(6'h08);
    drive(6'h00);
    @(negedge clk); pins = 6'h08;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 8'hF8; wdata = 8'h0D;
    @(negedge clk); wr_en = 0; addr = 0;
    chk("R7 set beats clear", {2'b0, irq}, 8'h08);
    wr(8'hF8, 8'h0D);
    chk("R7 later clear", {2'b0, irq}, 8'h00);
    drive(6'h00);

    wr(8'hF6, 8'hFF);
    addr = 8'hF6; #1;
    chk("R9 readback bit1", rdata, 8'h02);
    addr = 0;
    wr(8'hF6, 8'h02);
    drive(6'h03);
    chk("R8 level high", {2'b0, irq}, 8'h03);
    wr(8'hF8, 8'h0A);
    @(negedge clk);
    chk("R8 clear no effect", {2'b0, irq}, 8'h03);
    wr(8'hF6, 8'h06);
    @(negedge clk);
    chk("R8 bit2 ignored", {2'b0, irq}, 8'h03);
    drive(6'h00);
    chk("R11 pin1 sticky, R8 pin0 follows", {2'b0, irq}, 8'h02);
    wr(8'hF8, 8'h0B);
    drive(6'h01);
    wr(8'hF6, 8'h00);
    drive(6'h00);
    chk("R10 stale flag kept", {2'b0, irq}, 8'h01);
    wr(8'hF8, 8'h0A);
    chk("R10 cleared", {2'b0, irq}, 8'h00);

    exp = 0; pol = 0;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] m;
      m = 8'($urandom) & 8'hFD;
      wr(8'hF6, m);
      pol = m[7:2];
      np = 6'($urandom);
      exp = exp | edges(pins, np, pol);
      drive(np);
      chk("R2 R3 random edges", {2'b0, irq}, {2'b0, exp});
      code = 8'h08 + 8'($urandom_range(0, 9));
      wr(8'hF8, code);
      exp = after_clr(exp, code);
      chk("R5 R6 random clear", {2'b0, irq}, {2'b0, exp});
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule